// File: doc/BRIEF.md
# I/O Translation Unit Register File

This block is the software-visible register bank of an I/O address translation unit. It takes 32-bit word accesses on a 16 KB register window and decodes the word index (byte offset shifted right by two) to one of its registers. Each write is filtered through a per-register mask and may have constant bits forced on. Reads return the stored value in the same cycle. The block also derives the start address of the translated I/O window from a 3-bit range field in the control register.

A page-table walker outside the block reports translation faults through a one-cycle capture strobe. The strobe loads the fault status and fault address registers and raises the interrupt line. Any read or write of either fault register drops the line again. The mask ID register accumulates written bits by OR instead of replacing its contents.

Top module: `iotu_regfile`

## Requirements
- R1: After reset the registers read as follows. Control (0x0000) = {VER_ID, 24'h0}. Window start = 0. Arbitration enable (0x2000) = 0x00000008. Fault status (0x1000) = 0x00800000. Arbiter enable (0x1008) = 0x00000003. Mask ID (0x3018) = 0x23000000. Every other register = 0 and the interrupt is low.
- R2: A control write stores `wdata & 0x0000001D` and ORs VER_ID into bits 31:24.
- R3: A control write sets the window start to 0xFFFFFFFF shifted left by 24+r, where r is wdata[4:2]. So r=0 gives 0xFF000000 and r=7 gives 0x80000000. The window start changes on no other access.
- R4: A page-table base write (0x0004) stores `wdata & 0x07FFFC00`.
- R5: An arbiter enable write (0x1008) stores `(wdata & 0x801F000F) | 1`.
- R6: A fault status write stores `(wdata & 0xFF0FFFFF) | 0x00800000`. A fault address write (0x1004) stores all 32 bits.
- R7: A read or write of the fault status or fault address register, with no capture strobe in that cycle, leaves the interrupt low from the next cycle.
- R8: Each of the four slot configuration writes (0x1010, 0x1014, 0x1018, 0x101C) stores `wdata & 0x00010003`. An arbitration enable write stores `(wdata & 0x001F0000) | 0x8`.
- R9: A mask ID write sets the register to `old | (wdata & 0x00FFFFFF)`.
- R10: The TLB flush (0x0014) and page flush (0x0018) registers store the full written word. Unlisted offsets (for example 0x0008 and 0x3FFC) read 0 and ignore writes.
- R11: A capture strobe loads fault status with `(fault_status_i & 0xFF0FFFFF) | 0x00800000` and fault address with fault_addr_i, and sets the interrupt from the next cycle. It takes precedence over a same-cycle access to those registers, both for the register contents and for the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| word_addr_i | input | IDX_W | Word index (byte offset >> 2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| fault_set_i | input | 1 | One-cycle fault capture strobe |
| fault_status_i | input | 32 | Fault status to capture |
| fault_addr_i | input | 32 | Fault address to capture |
| win_start_o | output | 32 | Translation window start address |
| irq_o | output | 1 | Fault interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- a strobe always raises the interrupt, and the interrupt only rises after a strobe;
- an access to a fault register without a strobe always drops the interrupt;
- the window start holds unless control is written, and range 7 gives the 2 GB start;
- the forced bits of the arbiter enable, arbitration enable and fault status registers read as one.

The bench scenarios are needed for the rest:
- the exact write masks;
- the OR accumulation of the mask ID;
- the full-width flush storage and the unlisted offsets;
- the reset values;
- the precedence of a strobe over a same-cycle write.

// File: rtl/iotu_pkg.sv
package iotu_pkg;
  localparam int unsigned DW = 32;

  // byte offsets of the register window
  localparam int unsigned OFF_CTRL   = 32'h0000;
  localparam int unsigned OFF_BASE   = 32'h0004;
  localparam int unsigned OFF_TLBF   = 32'h0014;
  localparam int unsigned OFF_PGF    = 32'h0018;
  localparam int unsigned OFF_FSTAT  = 32'h1000;
  localparam int unsigned OFF_FADDR  = 32'h1004;
  localparam int unsigned OFF_AER    = 32'h1008;
  localparam int unsigned OFF_SLOT0  = 32'h1010;
  localparam int unsigned OFF_ARBEN  = 32'h2000;
  localparam int unsigned OFF_MASKID = 32'h3018;

  localparam logic [DW-1:0] CTRL_MASK   = 32'h0000_001D;
  localparam logic [DW-1:0] BASE_MASK   = 32'h07FF_FC00;
  localparam logic [DW-1:0] FSTAT_MASK  = 32'hFF0F_FFFF;
  localparam logic [DW-1:0] FSTAT_FORCE = 32'h0080_0000;
  localparam logic [DW-1:0] AER_MASK    = 32'h801F_000F;
  localparam logic [DW-1:0] AER_FORCE   = 32'h0000_0001;
  localparam logic [DW-1:0] AER_RST     = 32'h0000_0003;
  localparam logic [DW-1:0] SLOT_MASK   = 32'h0001_0003;
  localparam logic [DW-1:0] ARBEN_MASK  = 32'h001F_0000;
  localparam logic [DW-1:0] ARBEN_FORCE = 32'h0000_0008;
  localparam logic [DW-1:0] MASKID_MASK = 32'h00FF_FFFF;
  localparam logic [DW-1:0] MASKID_RST  = 32'h2300_0000;

  localparam int unsigned WIN_MIN_SHIFT = 24;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_BASE, SEL_TLBF, SEL_PGF, SEL_FSTAT,
    SEL_FADDR, SEL_AER, SEL_SLOT, SEL_ARBEN, SEL_MASKID
  } sel_e;
endpackage

// File: rtl/iotu_addr_dec.sv
module iotu_addr_dec
  import iotu_pkg::*;
#(
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned NSLOT  = 4,
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [IDX_W-1:0]  idx_i,
  output sel_e              sel_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int unsigned SLOT_IDX0 = OFF_SLOT0 >> 2;

  always_comb begin
    sel_o  = SEL_NONE;
    slot_o = '0;
    unique case (idx_i)
      IDX_W'(OFF_CTRL   >> 2): sel_o = SEL_CTRL;
      IDX_W'(OFF_BASE   >> 2): sel_o = SEL_BASE;
      IDX_W'(OFF_TLBF   >> 2): sel_o = SEL_TLBF;
      IDX_W'(OFF_PGF    >> 2): sel_o = SEL_PGF;
      IDX_W'(OFF_FSTAT  >> 2): sel_o = SEL_FSTAT;
      IDX_W'(OFF_FADDR  >> 2): sel_o = SEL_FADDR;
      IDX_W'(OFF_AER    >> 2): sel_o = SEL_AER;
      IDX_W'(OFF_ARBEN  >> 2): sel_o = SEL_ARBEN;
      IDX_W'(OFF_MASKID >> 2): sel_o = SEL_MASKID;
      default: begin
        for (int i = 0; i < NSLOT; i++) begin
          if (idx_i == IDX_W'(SLOT_IDX0 + i)) begin
            sel_o  = SEL_SLOT;
            slot_o = SLOT_W'(i);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/iotu_win_calc.sv
module iotu_win_calc
  import iotu_pkg::*;
(
  input  logic [2:0]    range_i,
  output logic [DW-1:0] start_o
);
  // each range step doubles the window, growing downward from the top
  always_comb start_o = {DW{1'b1}} << (WIN_MIN_SHIFT + 32'(range_i));
endmodule

// File: rtl/iotu_fault_regs.sv
module iotu_fault_regs
  import iotu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stat_i,
  input  logic          wr_addr_i,
  input  logic          touch_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] cap_stat_i,
  input  logic [DW-1:0] cap_addr_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] addr_o,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= FSTAT_FORCE;
      addr_o <= '0;
      irq_o  <= 1'b0;
    end else if (cap_i) begin
      // capture beats any same-cycle software access
      stat_o <= (cap_stat_i & FSTAT_MASK) | FSTAT_FORCE;
      addr_o <= cap_addr_i;
      irq_o  <= 1'b1;
    end else begin
      if (wr_stat_i) stat_o <= (wdata_i & FSTAT_MASK) | FSTAT_FORCE;
      if (wr_addr_i) addr_o <= wdata_i;
      if (touch_i)   irq_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/iotu_regfile.sv
module iotu_regfile
  import iotu_pkg::*;
#(
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned NSLOT  = 4,
  parameter logic [7:0]  VER_ID = 8'h41
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] word_addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             fault_set_i,
  input  logic [31:0]      fault_status_i,
  input  logic [31:0]      fault_addr_i,
  output logic [31:0]      win_start_o,
  output logic             irq_o
);
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [DW-1:0] VER_WORD = {VER_ID, {(DW-8){1'b0}}};

  sel_e              sel;
  logic [SLOT_W-1:0] slot;
  logic              wr, rd;
  logic [DW-1:0] ctrl_q, base_q, tlbf_q, pgf_q, aer_q, arben_q, maskid_q, win_q;
  logic [DW-1:0] slot_q [NSLOT];
  logic [DW-1:0] fstat, faddr, win_next;

  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  iotu_addr_dec #(.IDX_W(IDX_W), .NSLOT(NSLOT)) u_dec (
    .idx_i  (word_addr_i),
    .sel_o  (sel),
    .slot_o (slot)
  );

  iotu_win_calc u_win (
    .range_i (wdata_i[4:2]),
    .start_o (win_next)
  );

  iotu_fault_regs u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stat_i  (wr && sel == SEL_FSTAT),
    .wr_addr_i  (wr && sel == SEL_FADDR),
    .touch_i    ((wr | rd) && (sel == SEL_FSTAT || sel == SEL_FADDR)),
    .wdata_i    (wdata_i),
    .cap_i      (fault_set_i),
    .cap_stat_i (fault_status_i),
    .cap_addr_i (fault_addr_i),
    .stat_o     (fstat),
    .addr_o     (faddr),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= VER_WORD;
      base_q   <= '0;
      tlbf_q   <= '0;
      pgf_q    <= '0;
      aer_q    <= AER_RST;
      arben_q  <= ARBEN_FORCE;
      maskid_q <= MASKID_RST;
      win_q    <= '0;
    end else if (wr) begin
      unique case (sel)
        SEL_CTRL: begin
          ctrl_q <= (wdata_i & CTRL_MASK) | VER_WORD;
          win_q  <= win_next;
        end
        SEL_BASE:   base_q   <= wdata_i & BASE_MASK;
        SEL_TLBF:   tlbf_q   <= wdata_i;
        SEL_PGF:    pgf_q    <= wdata_i;
        SEL_AER:    aer_q    <= (wdata_i & AER_MASK) | AER_FORCE;
        SEL_ARBEN:  arben_q  <= (wdata_i & ARBEN_MASK) | ARBEN_FORCE;
        SEL_MASKID: maskid_q <= maskid_q | (wdata_i & MASKID_MASK);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       slot_q[g] <= '0;
      else if (wr && sel == SEL_SLOT && slot == SLOT_W'(g)) slot_q[g] <= wdata_i & SLOT_MASK;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rdata_o = ctrl_q;
      SEL_BASE:   rdata_o = base_q;
      SEL_TLBF:   rdata_o = tlbf_q;
      SEL_PGF:    rdata_o = pgf_q;
      SEL_FSTAT:  rdata_o = fstat;
      SEL_FADDR:  rdata_o = faddr;
      SEL_AER:    rdata_o = aer_q;
      SEL_SLOT:   rdata_o = slot_q[slot];
      SEL_ARBEN:  rdata_o = arben_q;
      SEL_MASKID: rdata_o = maskid_q;
      default:    rdata_o = '0;
    endcase
  end

  assign win_start_o = win_q;
endmodule

// File: rtl/iotu_regfile_chk.sv
module iotu_regfile_chk
  import iotu_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [IDX_W-1:0] word_addr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             fault_set_i,
  input logic [31:0]      fault_status_i,
  input logic [31:0]      fault_addr_i,
  input logic [31:0]      win_start_o,
  input logic             irq_o
);
  logic at_ctrl, at_fault, at_aer, at_fstat, at_arben;
  assign at_ctrl  = word_addr_i == IDX_W'(OFF_CTRL >> 2);
  assign at_fstat = word_addr_i == IDX_W'(OFF_FSTAT >> 2);
  assign at_fault = at_fstat || word_addr_i == IDX_W'(OFF_FADDR >> 2);
  assign at_aer   = word_addr_i == IDX_W'(OFF_AER >> 2);
  assign at_arben = word_addr_i == IDX_W'(OFF_ARBEN >> 2);

  p_strobe_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_set_i |=> irq_o);

  p_irq_source_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fault_set_i));

  p_clear_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && at_fault && !fault_set_i) |=> !irq_o);

  p_win_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && at_ctrl) |=> $stable(win_start_o));

  p_win_2g_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && at_ctrl && wdata_i[4:2] == 3'd7) |=> win_start_o == 32'h8000_0000);

  p_aer_force_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && at_aer) |-> rdata_o[0]);

  p_fstat_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && at_fstat) |-> rdata_o[23]);

  p_arben_force_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && at_arben) |-> rdata_o[3]);
endmodule

bind iotu_regfile iotu_regfile_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/iotu_regfile_tb_top.sv
module iotu_regfile_tb_top;
  localparam int unsigned IDX_W = 12;
  localparam logic [7:0] VER = 8'h41;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, fset = 1'b0;
  logic [IDX_W-1:0] waddr = '0;
  logic [31:0] wdata = '0, fstat_in = '0, faddr_in = '0;
  logic [31:0] rdata, win;
  logic irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // scoreboard: kind 0 = rdata, 1 = irq, 2 = window start
  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  event        chk_ev;

  always #4 clk = ~clk;

  iotu_regfile #(.IDX_W(IDX_W), .NSLOT(4), .VER_ID(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_addr_i(waddr),
    .wdata_i(wdata), .rdata_o(rdata), .fault_set_i(fset), .fault_status_i(fstat_in),
    .fault_addr_i(faddr_in), .win_start_o(win), .irq_o(irq)
  );

  initial begin
    forever begin
      @(chk_ev);
      #1;
      begin
        int k;
        logic [31:0] e, a;
        string t;
        k = q_kind.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = (k == 0) ? rdata : (k == 1) ? {31'b0, irq} : win;
        tests++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %08h expected %08h", t, a, e);
        end
      end
    end
  end

  task automatic push(input int k, input logic [31:0] e, input string t);
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
    -> chk_ev;
  endtask

  task automatic wr(input logic [31:0] off, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; waddr = IDX_W'(off >> 2); wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] off, input logic [31:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; waddr = IDX_W'(off >> 2);
    push(0, e, t);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic obs(input int k, input logic [31:0] e, input string t);
    @(negedge clk);
    push(k, e, t);
    #2;
  endtask

  task automatic strobe(input logic [31:0] s, input logic [31:0] a,
                        input bit acc, input bit w, input logic [31:0] off, input logic [31:0] d);
    @(negedge clk);
    fset = 1'b1; fstat_in = s; faddr_in = a;
    req = acc; we = w; waddr = IDX_W'(off >> 2); wdata = d;
    @(posedge clk); #1;
    fset = 1'b0; req = 1'b0; we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(32'h0000, {VER, 24'h0}, "R1 ctrl");
    obs(2, 32'h0, "R1 win");
    rd(32'h2000, 32'h8, "R1 arben");
    rd(32'h1000, 32'h0080_0000, "R1 fstat");
    rd(32'h1008, 32'h3, "R1 aer");
    rd(32'h3018, 32'h2300_0000, "R1 maskid");
    rd(32'h0004, 32'h0, "R1 base");
    obs(1, 32'h0, "R1 irq");

    // R2 / R3 control and window start
    wr(32'h0000, 32'hFFFF_FFFF);
    rd(32'h0000, {VER, 24'h1D}, "R2 ctrl mask");
    obs(2, 32'h8000_0000, "R3 win r7");
    for (int r = 0; r < 7; r++) begin
      wr(32'h0000, (32'(r) << 2) | 32'h1);
      obs(2, 32'hFFFF_FFFF << (24 + r), "R3 win range");
    end
    wr(32'h0004, 32'h0);
    obs(2, 32'hC000_0000, "R3 win held on other write");

    // R4 base
    wr(32'h0004, 32'hFFFF_FFFF);
    rd(32'h0004, 32'h07FF_FC00, "R4 base mask");

    // R5 arbiter enable
    wr(32'h1008, 32'h0);
    rd(32'h1008, 32'h1, "R5 aer force");
    wr(32'h1008, 32'hFFFF_FFFF);
    rd(32'h1008, 32'h801F_000F, "R5 aer mask");

    // R8 slots and arbitration enable
    for (int i = 0; i < 4; i++) begin
      wr(32'h1010 + 32'(4 * i), 32'hFFFF_FFFF);
      rd(32'h1010 + 32'(4 * i), 32'h0001_0003, "R8 slot mask");
    end
    wr(32'h2000, 32'h0);
    rd(32'h2000, 32'h8, "R8 arben force");
    wr(32'h2000, 32'hFFFF_FFFF);
    rd(32'h2000, 32'h001F_0008, "R8 arben mask");

    // R9 mask ID accumulates
    wr(32'h3018, 32'h0000_00F0);
    rd(32'h3018, 32'h2300_00F0, "R9 maskid or");
    wr(32'h3018, 32'hFF00_000F);
    rd(32'h3018, 32'h2300_00FF, "R9 maskid accum");

    // R10 flush registers and holes
    wr(32'h0014, 32'hDEAD_BEEF);
    rd(32'h0014, 32'hDEAD_BEEF, "R10 tlb flush");
    wr(32'h0018, 32'h1234_5678);
    rd(32'h0018, 32'h1234_5678, "R10 page flush");
    wr(32'h0008, 32'hFFFF_FFFF);
    rd(32'h0008, 32'h0, "R10 hole 0x0008");
    wr(32'h3FFC, 32'hFFFF_FFFF);
    rd(32'h3FFC, 32'h0, "R10 hole 0x3FFC");
    rd(32'h0000, {VER, 24'h19}, "R10 ctrl untouched by hole");

    // R11 capture, R7 clear by read
    strobe(32'hFFFF_FFFF, 32'hCAFE_F000, 1'b0, 1'b0, 32'h0, 32'h0);
    obs(1, 32'h1, "R11 irq set");
    rd(32'h1000, 32'hFF8F_FFFF, "R11 fstat capture");
    obs(1, 32'h0, "R7 irq cleared by fstat read");
    rd(32'h1004, 32'hCAFE_F000, "R11 faddr capture");

    // R6 / R7 writes
    strobe(32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0);
    obs(1, 32'h1, "R11 irq set again");
    wr(32'h1004, 32'h0000_0011);
    obs(1, 32'h0, "R7 irq cleared by faddr write");
    rd(32'h1004, 32'h0000_0011, "R6 faddr full");
    wr(32'h1000, 32'h0);
    rd(32'h1000, 32'h0080_0000, "R6 fstat force");
    wr(32'h1000, 32'hFFFF_FFFF);
    rd(32'h1000, 32'hFF8F_FFFF, "R6 fstat mask");

    // R11 precedence over same-cycle access
    strobe(32'h4000_0000, 32'h0000_A000, 1'b1, 1'b0, 32'h1000, 32'h0);
    obs(1, 32'h1, "R11 strobe wins over read clear");
    strobe(32'h1000_0000, 32'h0000_B000, 1'b1, 1'b1, 32'h1000, 32'h0);
    obs(1, 32'h1, "R11 strobe wins over write clear");
    rd(32'h1000, 32'h1080_0000, "R11 strobe wins over write data");
    rd(32'h1004, 32'h0000_B000, "R11 faddr from strobe");
    obs(1, 32'h0, "R7 cleared after read");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule